// File: doc/BRIEF.md
# Timer Compare Register Access Router

This block sits in the system-register access path of a processor core and decides what happens to a read or a write of the physical timer compare register. The register can be named through two instruction encodings: a primary one, and an alternate one that differs only in the op1 field and exists for a hypervisor running in host mode. For each request the block looks at the encoding, the current privilege level (0 to 3) and a set of control flags. The flags cover host mode, the trap enables at each level, the secure state, whether a secure hypervisor is implemented, and the three-bit nested-virtualization mode. From these it picks one of six actions.

The six actions are: access the local compare register, redirect to the hypervisor compare register, redirect to the secure hypervisor compare register, redirect to a memory slot at a fixed offset, trap with a fixed syndrome class to level 1 or level 2, or raise an undefined-instruction exception. Conditions are tested in strict priority order, and the first one that matches decides the action. The decision appears as a registered, one-hot action vector one cycle after the request. Register storage and memory live outside the block.

Top module: `tcr_access_router`

## Requirements
- R1: A request gets a response (`rsp_valid` high) exactly one cycle after `req_valid` if and only if it matches one of two encodings. The primary encoding is op0=3, op1=3, CRn=14, CRm=2, op2=2. The alternate encoding is the same with op1=5. Any other encoding produces no response.
- R2: `rsp_action` is one-hot whenever a response is valid, and all zero when none is. The bit positions are: bit0 local register, bit1 hypervisor compare, bit2 secure hypervisor compare, bit3 memory slot, bit4 trap, bit5 undefined. A trap response also carries `rsp_target` equal to 1 or 2 and `rsp_ec` equal to 0x18; any other response carries 0 in both. A memory response carries `rsp_mem_ofs` equal to 0x178; any other response carries 0 there.
- R3: Primary encoding at level 0, with `host_el0` clear and `el0_ctr_en` clear, traps. The trap goes to level 2 when `el2_enabled` and `trap_general` are both set; otherwise it goes to level 1. This check has the highest priority at level 0.
- R4: Primary encoding at level 0 or level 1, when no higher-priority check has matched: if `el2_enabled` is set, `host_el2` is clear and `el1_pcen` is clear, the request traps to level 2.
- R5: Primary encoding, when no higher-priority check has matched, traps to level 2 in these cases:
  - at level 1, `host_el2` is set and `el1_host_en` is clear;
  - at level 0, `host_el2` is set, `trap_general` is clear and `el1_host_en` is clear;
  - at level 0, `host_el0` is set and `el0_host_en` is clear.
- R6: Primary encoding at level 0, host mode, not trapped: with `secure_state` and `shyp_present` both set, the request goes to the secure hypervisor compare register. With `secure_state` clear, it goes to the hypervisor compare register. Otherwise it goes to the local register. Outside host mode, a request that is not trapped goes to the local register.
- R7: Primary encoding at level 1, not trapped: with `nv_mode` equal to 3'b111 the request goes to the memory slot; otherwise it goes to the local register.
- R8: Primary encoding at level 2 follows the R6 redirect rule, with `host_el2` in place of `host_el0`. Primary encoding at level 3 always goes to the local register.
- R9: Alternate encoding at level 0 is always undefined.
- R10: Alternate encoding at level 1 depends on `nv_mode`. With 3'b101, the request traps to level 2 when `el2_enabled` and `nv_pct_trap` are set and `host_el0` is clear; otherwise it goes to the memory slot. Any other mode with bit 0 set traps to level 2. All remaining modes are undefined.
- R11: Alternate encoding at level 2 or level 3 goes to the local register when `host_el2` is set, and is undefined otherwise.
- R12: Reads and writes take identical routing, and `rsp_write` repeats `req_write` of the request being answered.
- R13: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Current privilege level |
| el2_enabled | input | 1 | Level 2 is enabled |
| host_el0 | input | 1 | Level 0 runs under a host-mode hypervisor |
| host_el2 | input | 1 | Level 2 runs in host mode |
| trap_general | input | 1 | General trap-to-level-2 control |
| el0_ctr_en | input | 1 | Level-0 access enable set by level 1 |
| el1_pcen | input | 1 | Lower-level physical counter enable (non-host) |
| el1_host_en | input | 1 | Level-1 physical timer enable under host mode |
| el0_host_en | input | 1 | Level-0 physical timer enable under host mode |
| secure_state | input | 1 | Access made in secure state |
| shyp_present | input | 1 | Secure hypervisor feature implemented |
| nv_mode | input | 3 | Nested-virtualization mode |
| nv_pct_trap | input | 1 | Nested physical-counter trap control |
| rsp_valid | output | 1 | Decision valid |
| rsp_write | output | 1 | Direction of the answered request |
| rsp_action | output | 6 | One-hot action (see R2) |
| rsp_target | output | 2 | Trap target level, 0 unless trapping |
| rsp_ec | output | 6 | Syndrome class, 0x18 on trap, else 0 |
| rsp_mem_ofs | output | 12 | Memory slot offset, 0x178 on memory action, else 0 |

## Verification
Every result of this block is due one clock edge after the request: the encoding match, the action vector, the target level, the syndrome, the offset and the direction all come from a single register stage. The bench drives each request on a falling edge and compares all outputs at the next falling edge. That edge comes after exactly one rising edge, so each comparison sees the response to the request just applied and nothing older. Directed cases pin down each priority step and each nested-virtualization mode. Seeded random contexts then mix every flag against the three encoding kinds and all four levels.

// File: rtl/tcr_route_pkg.sv
// Shared types for the timer compare access router.
// Assumes a single 6-way action set; bit index of each action is its enum value.
package tcr_route_pkg;
    localparam int ACT_N = 6;
    localparam int ACT_W = $clog2(ACT_N);

    typedef enum logic [ACT_W-1:0] {
        ACT_LOCAL = 3'd0,
        ACT_HYP   = 3'd1,
        ACT_SHYP  = 3'd2,
        ACT_MEM   = 3'd3,
        ACT_TRAP  = 3'd4,
        ACT_UNDEF = 3'd5
    } act_e;

    typedef struct packed {
        act_e       act;
        logic [1:0] tgt;
    } dec_t;
endpackage

// File: rtl/tcr_enc_match.sv
// Encoding matcher: flags whether the request names the compare register
// through the primary or the alternate encoding. Assumes both encodings
// share every field except op1.
module tcr_enc_match #(
    parameter logic [1:0] OP0     = 2'b11,
    parameter logic [2:0] OP1_PRI = 3'b011,
    parameter logic [2:0] OP1_ALT = 3'b101,
    parameter logic [3:0] CRN     = 4'b1110,
    parameter logic [3:0] CRM     = 4'b0010,
    parameter logic [2:0] OP2     = 3'b010
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       pri_hit,
    output logic       alt_hit
);
    logic common_ok;

    // Compare the fields shared by both encodings, then split on op1.
    always_comb begin
        common_ok = (op0 == OP0) && (crn == CRN) && (crm == CRM) && (op2 == OP2);
        pri_hit   = common_ok && (op1 == OP1_PRI);
        alt_hit   = common_ok && (op1 == OP1_ALT);
    end
endmodule

// File: rtl/tcr_pri_route.sv
// Priority decision tree for the primary encoding. Purely combinational.
// Assumes the caller only uses the result when the primary encoding matched.
module tcr_pri_route
    import tcr_route_pkg::*;
(
    input  logic [1:0] level,
    input  logic       el2_en,
    input  logic       host_el0,
    input  logic       host_el2,
    input  logic       tge,
    input  logic       el0_ctr_en,
    input  logic       el1_pcen,
    input  logic       el1_host_en,
    input  logic       el0_host_en,
    input  logic       secure,
    input  logic       shyp_present,
    input  logic [2:0] nv_mode,
    output dec_t       dec
);
    // First matching condition per level wins; target is 0 unless trapping.
    always_comb begin
        dec.act = ACT_LOCAL;
        dec.tgt = 2'd0;
        unique case (level)
            2'd0: begin
                if (!host_el0 && !el0_ctr_en) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = (el2_en && tge) ? 2'd2 : 2'd1;
                end else if (el2_en && !host_el2 && !el1_pcen) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end else if (host_el2 && !tge && !el1_host_en) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end else if (host_el0 && !el0_host_en) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end else if (host_el0 && secure && shyp_present) begin
                    dec.act = ACT_SHYP;
                end else if (host_el0 && !secure) begin
                    dec.act = ACT_HYP;
                end
            end
            2'd1: begin
                if (el2_en && !host_el2 && !el1_pcen) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end else if (host_el2 && !el1_host_en) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end else if (nv_mode == 3'b111) begin
                    dec.act = ACT_MEM;
                end
            end
            2'd2: begin
                if (host_el2 && secure && shyp_present) begin
                    dec.act = ACT_SHYP;
                end else if (host_el2 && !secure) begin
                    dec.act = ACT_HYP;
                end
            end
            default: dec.act = ACT_LOCAL;
        endcase
    end
endmodule

// File: rtl/tcr_alt_route.sv
// Decision tree for the alternate (host-mode alias) encoding. Combinational.
// Assumes the caller only uses the result when the alternate encoding matched.
module tcr_alt_route
    import tcr_route_pkg::*;
(
    input  logic [1:0] level,
    input  logic       el2_en,
    input  logic       host_el0,
    input  logic       host_el2,
    input  logic [2:0] nv_mode,
    input  logic       nv_pct_trap,
    output dec_t       dec
);
    // Level 0 undefined; level 1 by nested mode; levels 2/3 by host mode.
    always_comb begin
        dec.act = ACT_UNDEF;
        dec.tgt = 2'd0;
        unique case (level)
            2'd0: dec.act = ACT_UNDEF;
            2'd1: begin
                if (nv_mode == 3'b101) begin
                    if (el2_en && !host_el0 && nv_pct_trap) begin
                        dec.act = ACT_TRAP;
                        dec.tgt = 2'd2;
                    end else begin
                        dec.act = ACT_MEM;
                    end
                end else if (nv_mode[0]) begin
                    dec.act = ACT_TRAP;
                    dec.tgt = 2'd2;
                end
            end
            default: dec.act = host_el2 ? ACT_LOCAL : ACT_UNDEF;
        endcase
    end
endmodule

// File: rtl/tcr_access_router.sv
// Timer compare access router top. Matches the encoding, runs both decision
// trees in parallel, selects by encoding and registers a one-hot action with
// target level, syndrome class and memory offset. One cycle of latency.
// Assumes requests are single-cycle pulses; no backpressure.
module tcr_access_router
    import tcr_route_pkg::*;
#(
    parameter int               EC_W    = 6,
    parameter logic [EC_W-1:0]  TRAP_EC = 6'h18,
    parameter int               OFS_W   = 12,
    parameter logic [OFS_W-1:0] MEM_OFS = 12'h178
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_op0,
    input  logic [2:0]           req_op1,
    input  logic [3:0]           req_crn,
    input  logic [3:0]           req_crm,
    input  logic [2:0]           req_op2,
    input  logic [1:0]           cur_level,
    input  logic                 el2_enabled,
    input  logic                 host_el0,
    input  logic                 host_el2,
    input  logic                 trap_general,
    input  logic                 el0_ctr_en,
    input  logic                 el1_pcen,
    input  logic                 el1_host_en,
    input  logic                 el0_host_en,
    input  logic                 secure_state,
    input  logic                 shyp_present,
    input  logic [2:0]           nv_mode,
    input  logic                 nv_pct_trap,
    output logic                 rsp_valid,
    output logic                 rsp_write,
    output logic [ACT_N-1:0]     rsp_action,
    output logic [1:0]           rsp_target,
    output logic [EC_W-1:0]      rsp_ec,
    output logic [OFS_W-1:0]     rsp_mem_ofs
);
    logic             pri_hit;
    logic             alt_hit;
    logic             hit_v;
    dec_t             pri_dec;
    dec_t             alt_dec;
    dec_t             sel_dec;
    logic [ACT_N-1:0] act_vec;
    logic [EC_W-1:0]  ec_nxt;
    logic [OFS_W-1:0] ofs_nxt;
    logic [1:0]       tgt_nxt;

    tcr_enc_match u_match (
        .op0     (req_op0),
        .op1     (req_op1),
        .crn     (req_crn),
        .crm     (req_crm),
        .op2     (req_op2),
        .pri_hit (pri_hit),
        .alt_hit (alt_hit)
    );

    tcr_pri_route u_pri (
        .level        (cur_level),
        .el2_en       (el2_enabled),
        .host_el0     (host_el0),
        .host_el2     (host_el2),
        .tge          (trap_general),
        .el0_ctr_en   (el0_ctr_en),
        .el1_pcen     (el1_pcen),
        .el1_host_en  (el1_host_en),
        .el0_host_en  (el0_host_en),
        .secure       (secure_state),
        .shyp_present (shyp_present),
        .nv_mode      (nv_mode),
        .dec          (pri_dec)
    );

    tcr_alt_route u_alt (
        .level       (cur_level),
        .el2_en      (el2_enabled),
        .host_el0    (host_el0),
        .host_el2    (host_el2),
        .nv_mode     (nv_mode),
        .nv_pct_trap (nv_pct_trap),
        .dec         (alt_dec)
    );

    // Pick the tree that belongs to the matched encoding.
    always_comb begin
        hit_v   = req_valid && (pri_hit || alt_hit);
        sel_dec = pri_hit ? pri_dec : alt_dec;
    end

    // Expand the selected action into its one-hot bit.
    for (genvar gi = 0; gi < ACT_N; gi++) begin : g_onehot
        assign act_vec[gi] = hit_v && (int'(sel_dec.act) == gi);
    end

    // Side fields that only accompany trap or memory actions.
    always_comb begin
        tgt_nxt = act_vec[ACT_TRAP] ? sel_dec.tgt : 2'd0;
        ec_nxt  = act_vec[ACT_TRAP] ? TRAP_EC : '0;
        ofs_nxt = act_vec[ACT_MEM]  ? MEM_OFS : '0;
    end

    // Response register; cleared by reset and on cycles without a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_write   <= 1'b0;
            rsp_action  <= '0;
            rsp_target  <= 2'd0;
            rsp_ec      <= '0;
            rsp_mem_ofs <= '0;
        end else begin
            rsp_valid   <= hit_v;
            rsp_write   <= hit_v && req_write;
            rsp_action  <= act_vec;
            rsp_target  <= tgt_nxt;
            rsp_ec      <= ec_nxt;
            rsp_mem_ofs <= ofs_nxt;
        end
    end
endmodule

// File: rtl/tcr_access_router_chk.sv
// Property checker for the timer compare access router, bound to the top.
// Assumes synchronous active-low reset; all properties are masked in reset.
module tcr_access_router_chk #(
    parameter int               EC_W    = 6,
    parameter logic [EC_W-1:0]  TRAP_EC = 6'h18,
    parameter int               OFS_W   = 12,
    parameter logic [OFS_W-1:0] MEM_OFS = 12'h178
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_op0,
    input logic [2:0]       req_op1,
    input logic [3:0]       req_crn,
    input logic [3:0]       req_crm,
    input logic [2:0]       req_op2,
    input logic [1:0]       cur_level,
    input logic             rsp_valid,
    input logic             rsp_write,
    input logic [5:0]       rsp_action,
    input logic [1:0]       rsp_target,
    input logic [EC_W-1:0]  rsp_ec,
    input logic [OFS_W-1:0] rsp_mem_ofs
);
    logic base_ok;
    logic is_pri;
    logic is_alt;

    // Independent view of the two encodings from the request pins.
    always_comb begin
        base_ok = (req_op0 == 2'd3) && (req_crn == 4'd14) && (req_crm == 4'd2) && (req_op2 == 3'd2);
        is_pri  = req_valid && base_ok && (req_op1 == 3'd3);
        is_alt  = req_valid && base_ok && (req_op1 == 3'd5);
    end

    AST_HIT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pri || is_alt) |=> rsp_valid); // R1
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_pri || is_alt) |=> !rsp_valid); // R1
    AST_ACTION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_action) == 1); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_action == 6'd0 && rsp_target == 2'd0 && rsp_ec == '0)); // R2
    AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_action[4]) |-> (rsp_ec == TRAP_EC && rsp_target != 2'd0 && rsp_target != 2'd3)); // R2
    AST_NONTRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_action[4]) |-> (rsp_ec == '0 && rsp_target == 2'd0)); // R2
    AST_MEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_action[3]) |-> rsp_mem_ofs == MEM_OFS); // R7
    AST_TOP_LEVEL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pri && cur_level == 2'd3) |=> rsp_action == 6'b000001); // R8
    AST_ALT_L0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (is_alt && cur_level == 2'd0) |=> rsp_action == 6'b100000); // R9
    AST_DIR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pri || is_alt) |=> rsp_write == $past(req_write)); // R12
endmodule

bind tcr_access_router tcr_access_router_chk #(
    .EC_W    (EC_W),
    .TRAP_EC (TRAP_EC),
    .OFS_W   (OFS_W),
    .MEM_OFS (MEM_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_op0     (req_op0),
    .req_op1     (req_op1),
    .req_crn     (req_crn),
    .req_crm     (req_crm),
    .req_op2     (req_op2),
    .cur_level   (cur_level),
    .rsp_valid   (rsp_valid),
    .rsp_write   (rsp_write),
    .rsp_action  (rsp_action),
    .rsp_target  (rsp_target),
    .rsp_ec      (rsp_ec),
    .rsp_mem_ofs (rsp_mem_ofs)
);

// File: tb/tcr_access_router_tb.sv
`timescale 1ns/1ps
// Bench for the timer compare access router: directed corners plus seeded
// random contexts, each checked one cycle after the request.
module tcr_access_router_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_op0;
    logic [2:0]  req_op1;
    logic [3:0]  req_crn, req_crm;
    logic [2:0]  req_op2;
    logic [1:0]  cur_level;
    logic        el2_enabled, host_el0, host_el2, trap_general;
    logic        el0_ctr_en, el1_pcen, el1_host_en, el0_host_en;
    logic        secure_state, shyp_present, nv_pct_trap;
    logic [2:0]  nv_mode;
    logic        rsp_valid, rsp_write;
    logic [5:0]  rsp_action;
    logic [1:0]  rsp_target;
    logic [5:0]  rsp_ec;
    logic [11:0] rsp_mem_ofs;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tcr_access_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .cur_level(cur_level), .el2_enabled(el2_enabled),
        .host_el0(host_el0), .host_el2(host_el2), .trap_general(trap_general),
        .el0_ctr_en(el0_ctr_en), .el1_pcen(el1_pcen), .el1_host_en(el1_host_en),
        .el0_host_en(el0_host_en), .secure_state(secure_state),
        .shyp_present(shyp_present), .nv_mode(nv_mode), .nv_pct_trap(nv_pct_trap),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_action(rsp_action),
        .rsp_target(rsp_target), .rsp_ec(rsp_ec), .rsp_mem_ofs(rsp_mem_ofs)
    );

    // Action indices as fixed by R2.
    localparam int A_LOC = 0, A_HYP = 1, A_SHYP = 2, A_MEM = 3, A_TRAP = 4, A_UND = 5;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference decision computed from the requirements.
    function automatic void ref_route(output int act, output logic [1:0] tgt, output string tag);
        bit pri, alt;
        pri = req_op0 == 2'd3 && req_op1 == 3'd3 && req_crn == 4'd14 && req_crm == 4'd2 && req_op2 == 3'd2;
        alt = req_op0 == 2'd3 && req_op1 == 3'd5 && req_crn == 4'd14 && req_crm == 4'd2 && req_op2 == 3'd2;
        act = -1; tgt = 2'd0; tag = "R1";
        if (pri) begin
            if (cur_level == 2'd0) begin
                if (!host_el0 && !el0_ctr_en) begin
                    act = A_TRAP; tgt = (el2_enabled && trap_general) ? 2'd2 : 2'd1; tag = "R3";
                end else if (el2_enabled && !host_el2 && !el1_pcen) begin
                    act = A_TRAP; tgt = 2'd2; tag = "R4";
                end else if ((host_el2 && !trap_general && !el1_host_en) || (host_el0 && !el0_host_en)) begin
                    act = A_TRAP; tgt = 2'd2; tag = "R5";
                end else begin
                    tag = "R6";
                    if (host_el0 && secure_state && shyp_present) act = A_SHYP;
                    else if (host_el0 && !secure_state) act = A_HYP;
                    else act = A_LOC;
                end
            end else if (cur_level == 2'd1) begin
                if (el2_enabled && !host_el2 && !el1_pcen) begin
                    act = A_TRAP; tgt = 2'd2; tag = "R4";
                end else if (host_el2 && !el1_host_en) begin
                    act = A_TRAP; tgt = 2'd2; tag = "R5";
                end else begin
                    act = (nv_mode == 3'b111) ? A_MEM : A_LOC; tag = "R7";
                end
            end else if (cur_level == 2'd2) begin
                tag = "R8";
                if (host_el2 && secure_state && shyp_present) act = A_SHYP;
                else if (host_el2 && !secure_state) act = A_HYP;
                else act = A_LOC;
            end else begin
                act = A_LOC; tag = "R8";
            end
        end else if (alt) begin
            if (cur_level == 2'd0) begin
                act = A_UND; tag = "R9";
            end else if (cur_level == 2'd1) begin
                tag = "R10";
                if (nv_mode == 3'b101) begin
                    if (el2_enabled && !host_el0 && nv_pct_trap) begin act = A_TRAP; tgt = 2'd2; end
                    else act = A_MEM;
                end else if (nv_mode[0]) begin
                    act = A_TRAP; tgt = 2'd2;
                end else act = A_UND;
            end else begin
                act = host_el2 ? A_LOC : A_UND; tag = "R11";
            end
        end
    endfunction

    // Apply the current inputs, wait one edge, compare every output.
    task automatic issue_and_check();
        int exp_act;
        logic [1:0] exp_tgt;
        string tag;
        logic [5:0] exp_vec;
        bit hit;
        ref_route(exp_act, exp_tgt, tag);
        hit = req_valid && exp_act >= 0;
        exp_vec = hit ? 6'(1 << exp_act) : 6'd0;
        @(negedge clk);
        check({tag, " valid/action"}, {25'd0, rsp_valid, rsp_action}, {25'd0, hit, exp_vec});
        check("R2 side fields", {12'd0, rsp_target, rsp_ec, rsp_mem_ofs},
              {12'd0, hit && exp_act == A_TRAP ? exp_tgt : 2'd0,
               hit && exp_act == A_TRAP ? 6'h18 : 6'h00,
               hit && exp_act == A_MEM ? 12'h178 : 12'h000});
        if (hit) check("R12 direction", {31'd0, rsp_write}, {31'd0, req_write});
    endtask

    task automatic set_enc(input int kind);
        req_op0 = 2'd3; req_op1 = (kind == 1) ? 3'd5 : 3'd3;
        req_crn = 4'd14; req_crm = 4'd2; req_op2 = 3'd2;
        if (kind == 2) begin
            case ($urandom_range(0, 3))
                0: req_crm = 4'd3;
                1: req_op1 = 3'd1;
                2: req_op2 = 3'd1;
                default: req_op0 = 2'd2;
            endcase
        end
    endtask

    task automatic clear_ctx();
        req_valid = 1'b1; req_write = 1'b0; cur_level = 2'd0;
        el2_enabled = 0; host_el0 = 0; host_el2 = 0; trap_general = 0;
        el0_ctr_en = 1; el1_pcen = 1; el1_host_en = 1; el0_host_en = 1;
        secure_state = 0; shyp_present = 0; nv_mode = 3'd0; nv_pct_trap = 0;
        set_enc(0);
    endtask

    task automatic rand_ctx();
        logic [15:0] r;
        r = 16'($urandom);
        req_valid = ($urandom_range(0, 7) != 0); req_write = r[0];
        cur_level = r[2:1]; el2_enabled = r[3]; host_el0 = r[4]; host_el2 = r[5];
        trap_general = r[6]; el0_ctr_en = r[7]; el1_pcen = r[8]; el1_host_en = r[9];
        el0_host_en = r[10]; secure_state = r[11]; shyp_present = r[12];
        nv_mode = r[15:13]; nv_pct_trap = 1'($urandom);
        set_enc($urandom_range(0, 4) < 2 ? 0 : ($urandom_range(0, 3) == 0 ? 2 : 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        clear_ctx();
        repeat (3) @(negedge clk);
        // R13: outputs held at zero in reset even with a live request.
        check("R13 reset outputs", {7'd0, rsp_valid, rsp_write, rsp_action, rsp_target, rsp_ec, rsp_mem_ofs}, 32'd0);
        rst_n = 1'b1;

        clear_ctx(); cur_level = 2'd3; el0_ctr_en = 0; el1_pcen = 0; issue_and_check(); // R8 top level
        clear_ctx(); set_enc(1); issue_and_check();                                      // R9
        clear_ctx(); cur_level = 2'd1; nv_mode = 3'b111; issue_and_check();                // R7 memory
        clear_ctx(); el0_ctr_en = 0; el2_enabled = 1; trap_general = 1; issue_and_check(); // R3 to 2
        clear_ctx(); el0_ctr_en = 0; el2_enabled = 1; issue_and_check();                   // R3 to 1
        clear_ctx(); el2_enabled = 1; el1_pcen = 0; cur_level = 2'd1; issue_and_check();   // R4
        clear_ctx(); host_el0 = 1; el0_host_en = 0; issue_and_check();                     // R5
        clear_ctx(); host_el0 = 1; secure_state = 1; shyp_present = 1; issue_and_check();  // R6 secure
        clear_ctx(); host_el0 = 1; issue_and_check();                                      // R6 nonsecure
        clear_ctx(); set_enc(1); cur_level = 2'd1; nv_mode = 3'b101; el2_enabled = 1; nv_pct_trap = 1; issue_and_check(); // R10 trap
        clear_ctx(); set_enc(1); cur_level = 2'd1; nv_mode = 3'b101; host_el0 = 1; nv_pct_trap = 1; el2_enabled = 1; issue_and_check(); // R10 memory
        clear_ctx(); set_enc(1); cur_level = 2'd1; nv_mode = 3'b011; issue_and_check();    // R10 other odd
        clear_ctx(); set_enc(1); cur_level = 2'd1; nv_mode = 3'b100; issue_and_check();    // R10 undef
        clear_ctx(); set_enc(1); cur_level = 2'd2; host_el2 = 1; issue_and_check();        // R11 local
        clear_ctx(); set_enc(1); cur_level = 2'd3; issue_and_check();                      // R11 undef
        clear_ctx(); set_enc(2); issue_and_check();                                        // R1 miss
        clear_ctx(); req_write = 1; cur_level = 2'd2; host_el2 = 1; issue_and_check();     // R12 with R8 hyp

        for (int i = 0; i < 3000; i++) begin
            rand_ctx();
            issue_and_check();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule